// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns eight raw interrupt input lines into a latched request vector. Each line is sampled once per clock. A per-line trigger-select bit decides how that line behaves. In level mode the request bit follows the input. In edge mode the request bit is set by a low-to-high transition and stays set until the line is acknowledged. The block remembers the level of each input from the previous clock, and edge detection uses that stored level.

The trigger-select register is written as a whole byte. A constant mask, fixed per instance, decides which of its bits can be set; the other bits stay zero. A mask vector from outside the block blocks lines from the pending output and changes how each new request is reported. For every line, a one-cycle pair of flags reports each set event: either a fresh unmasked request, or a request on a masked line. An acknowledge port names the line being serviced, so that its latched edge request can be dropped. Priority resolution and in-service tracking are done downstream from the pending vector.

Top module: `irq_request_latch`

## Requirements
- R1: A line whose trigger-select bit is 1 (level mode) has its request bit equal, after each rising clock edge, to the input level sampled at that edge.
- R2: A line whose trigger-select bit is 0 (edge mode) has its request bit set at an edge where its input is 1 and its stored previous level is 0.
- R3: An edge-mode request bit stays set when the input falls or stays high, until that line is acknowledged.
- R4: At every clock edge the stored previous level of every line takes the current input level, whatever the line's mode.
- R5: A write to the trigger-select register stores `trig_wr_data & WRITE_MASK` (default mask 0xF8), so bits outside the mask read back as 0. The new value governs sampling from the following edge onward.
- R6: An acknowledge (`ack_valid` with line index `ack_line`) clears an edge-mode request bit at the next edge. If that same edge also sees a rising input on that line, the request stays set.
- R7: An acknowledge of a level-mode line has no effect on its request bit.
- R8: When a line's set condition holds at an edge, `new_evt[n]` is 1 for the following cycle only if the request bit was clear before and `line_mask[n]` is 0. `masked_evt[n]` is 1 if `line_mask[n]` is 1. Both flags are 0 when there is no set condition, and the two are never 1 together.
- R9: `pend_vec` equals `req_vec & ~line_mask`, combinationally, with no clock edge needed.
- R10: Reset (`rst_n` low, asynchronous) clears the request register, the previous-level register, the trigger-select register and both event flag vectors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 8 | Raw interrupt input levels |
| trig_wr_en | input | 1 | Write strobe for the trigger-select register |
| trig_wr_data | input | 8 | Trigger-select write data (1 = level, 0 = edge) |
| line_mask | input | 8 | Per-line mask, 1 = masked |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_line | input | 3 | Index of the line being acknowledged |
| req_vec | output | 8 | Request register |
| trig_sel | output | 8 | Trigger-select register readback |
| pend_vec | output | 8 | Unmasked requests |
| new_evt | output | 8 | Fresh unmasked request latched this cycle |
| masked_evt | output | 8 | Set event on a masked line this cycle |

## Verification
Input levels, writes and acknowledges are applied before a rising edge. `req_vec`, `trig_sel`, `new_evt` and `masked_evt` change at that single edge, one register deep. `pend_vec` follows `line_mask` with no edge at all. The bench drives on the falling edge, lets one rising edge pass, and samples at the next falling edge, so each registered result is read exactly one edge after its stimulus. The combinational path is checked after a mask change by waiting a short delay, with no clock edge in between. Same-edge cases are hit on purpose: an acknowledge together with a rising input, and a trigger-select write in the cycle before the input is sampled under the new mode.

// File: rtl/irql_pkg.sv
package irql_pkg;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;

  // Set condition for one line: level mode wants a high input,
  // edge mode wants a high input after a stored low level.
  function automatic logic line_set(input logic is_level,
                                    input logic lvl,
                                    input logic prev);
    if (is_level) line_set = lvl;
    else          line_set = lvl & ~prev;
  endfunction

  // Next request bit for one line.
  function automatic logic line_next_req(input logic is_level,
                                         input logic lvl,
                                         input logic set,
                                         input logic ack,
                                         input logic req);
    if (is_level)  line_next_req = lvl;
    else if (set)  line_next_req = 1'b1;
    else if (ack)  line_next_req = 1'b0;
    else           line_next_req = req;
  endfunction

  // Fresh request report: only for a clear bit on an open line.
  function automatic logic evt_fresh(input logic set,
                                     input logic req,
                                     input logic masked);
    evt_fresh = set & ~req & ~masked;
  endfunction

  function automatic logic evt_blocked(input logic set,
                                       input logic masked);
    evt_blocked = set & masked;
  endfunction

endpackage

// File: rtl/irql_trig_reg.sv
module irql_trig_reg #(
  parameter int                 NUM_LINES  = 8,
  parameter logic [NUM_LINES-1:0] WRITE_MASK = 8'hF8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [NUM_LINES-1:0] wr_data,
  output logic [NUM_LINES-1:0] sel_q
);

  logic [NUM_LINES-1:0] wr_kept;

  assign wr_kept = wr_data & WRITE_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_q <= '0;
    else if (wr_en) sel_q <= wr_kept;
  end

endmodule

// File: rtl/irql_ack_decode.sv
module irql_ack_decode #(
  parameter int NUM_LINES = 8,
  localparam int IDXW     = $clog2(NUM_LINES)
) (
  input  logic                 ack_valid,
  input  logic [IDXW-1:0]      ack_line,
  output logic [NUM_LINES-1:0] ack_hit
);

  always_comb begin
    ack_hit = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (ack_valid && (ack_line == IDXW'(i))) ack_hit[i] = 1'b1;
    end
  end

endmodule

// File: rtl/irql_line_cell.sv
module irql_line_cell
  import irql_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic mode,
  input  logic ack,
  input  logic masked,
  output logic set_now,
  output logic req_q,
  output logic prev_q,
  output logic fresh_q,
  output logic blocked_q
);

  logic req_d;
  logic fresh_d;
  logic blocked_d;

  assign set_now   = line_set(mode, lvl, prev_q);
  assign req_d     = line_next_req(mode, lvl, set_now, ack, req_q);
  assign fresh_d   = evt_fresh(set_now, req_q, masked);
  assign blocked_d = evt_blocked(set_now, masked);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      prev_q    <= 1'b0;
      fresh_q   <= 1'b0;
      blocked_q <= 1'b0;
    end else begin
      req_q     <= req_d;
      prev_q    <= lvl;
      fresh_q   <= fresh_d;
      blocked_q <= blocked_d;
    end
  end

endmodule

// File: rtl/irq_request_latch.sv
module irq_request_latch #(
  parameter int                   NUM_LINES  = 8,
  parameter logic [NUM_LINES-1:0] WRITE_MASK = 8'hF8,
  localparam int                  IDXW       = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic                 trig_wr_en,
  input  logic [NUM_LINES-1:0] trig_wr_data,
  input  logic [NUM_LINES-1:0] line_mask,
  input  logic                 ack_valid,
  input  logic [IDXW-1:0]      ack_line,
  output logic [NUM_LINES-1:0] req_vec,
  output logic [NUM_LINES-1:0] trig_sel,
  output logic [NUM_LINES-1:0] pend_vec,
  output logic [NUM_LINES-1:0] new_evt,
  output logic [NUM_LINES-1:0] masked_evt
);

  // Named internal events, also used by the bound checker
  logic [NUM_LINES-1:0] ack_onehot;
  logic [NUM_LINES-1:0] prev_q;
  logic [NUM_LINES-1:0] set_vec;

  irql_trig_reg #(
    .NUM_LINES  (NUM_LINES),
    .WRITE_MASK (WRITE_MASK)
  ) trig_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (trig_wr_en),
    .wr_data (trig_wr_data),
    .sel_q   (trig_sel)
  );

  irql_ack_decode #(
    .NUM_LINES (NUM_LINES)
  ) ack_i (
    .ack_valid (ack_valid),
    .ack_line  (ack_line),
    .ack_hit   (ack_onehot)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    irql_line_cell cell_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl       (line_in[g]),
      .mode      (trig_sel[g]),
      .ack       (ack_onehot[g]),
      .masked    (line_mask[g]),
      .set_now   (set_vec[g]),
      .req_q     (req_vec[g]),
      .prev_q    (prev_q[g]),
      .fresh_q   (new_evt[g]),
      .blocked_q (masked_evt[g])
    );
  end

  assign pend_vec = req_vec & ~line_mask;

endmodule

// File: rtl/irql_checker.sv
module irql_checker #(
  parameter int                   N          = 8,
  parameter logic [N-1:0]         WRITE_MASK = 8'hF8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] line_in,
  input logic [N-1:0] trig_sel,
  input logic [N-1:0] ack_onehot,
  input logic [N-1:0] prev_q,
  input logic [N-1:0] req_vec,
  input logic [N-1:0] new_evt,
  input logic [N-1:0] masked_evt
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((($past(line_in) ^ req_vec) & $past(trig_sel)) == '0)); // R1

  AST_EDGE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (($past(line_in) & ~$past(prev_q) & ~$past(trig_sel) & ~req_vec) == '0)); // R2

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (($past(req_vec) & ~$past(trig_sel) & ~$past(ack_onehot) & ~req_vec) == '0)); // R3

  AST_PREV_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (prev_q == $past(line_in))); // R4

  AST_TRIG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_sel & ~WRITE_MASK) == '0); // R5

  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (($past(ack_onehot) & ~$past(trig_sel)
                  & ~($past(line_in) & ~$past(prev_q)) & req_vec) == '0)); // R6

  AST_ACK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (($past(ack_onehot) & $past(trig_sel) & ($past(line_in) ^ req_vec)) == '0)); // R7

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (new_evt & masked_evt) == '0); // R8

  AST_FRESH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((new_evt & ($past(req_vec) | ~req_vec)) == '0)); // R8

endmodule

bind irq_request_latch irql_checker #(
  .N          (NUM_LINES),
  .WRITE_MASK (WRITE_MASK)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_in    (line_in),
  .trig_sel   (trig_sel),
  .ack_onehot (ack_onehot),
  .prev_q     (prev_q),
  .req_vec    (req_vec),
  .new_evt    (new_evt),
  .masked_evt (masked_evt)
);

// File: tb/irq_request_latch_tb_top.sv
module irq_request_latch_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] line_in = '0;
  logic       trig_wr_en = 1'b0;
  logic [7:0] trig_wr_data = '0;
  logic [7:0] line_mask = '0;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_line = '0;
  logic [7:0] req_vec, trig_sel, pend_vec, new_evt, masked_evt;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_request_latch dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_in      (line_in),
    .trig_wr_en   (trig_wr_en),
    .trig_wr_data (trig_wr_data),
    .line_mask    (line_mask),
    .ack_valid    (ack_valid),
    .ack_line     (ack_line),
    .req_vec      (req_vec),
    .trig_sel     (trig_sel),
    .pend_vec     (pend_vec),
    .new_evt      (new_evt),
    .masked_evt   (masked_evt)
  );

  typedef struct packed {
    logic       wr;
    logic [7:0] wdata;
    logic [7:0] lines;
    logic [7:0] mask;
    logic       av;
    logic [2:0] al;
    logic [7:0] e_req;
    logic [7:0] e_new;
    logic [7:0] e_msk;
    logic [7:0] e_trig;
  } vec_t;

  // Default write mask 0xF8: lines 3..7 may be level, 0..2 stay edge.
  localparam vec_t VECS [0:9] = '{
    '{1'b1, 8'hFF, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00, 8'hF8},
    '{1'b0, 8'h00, 8'h11, 8'h00, 1'b0, 3'd0, 8'h11, 8'h11, 8'h00, 8'hF8},
    '{1'b0, 8'h00, 8'h11, 8'h10, 1'b0, 3'd0, 8'h11, 8'h00, 8'h10, 8'hF8},
    '{1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 3'd0, 8'h01, 8'h00, 8'h00, 8'hF8},
    '{1'b0, 8'h00, 8'h00, 8'h00, 1'b1, 3'd0, 8'h00, 8'h00, 8'h00, 8'hF8},
    '{1'b0, 8'h00, 8'h12, 8'h02, 1'b0, 3'd0, 8'h12, 8'h10, 8'h02, 8'hF8},
    '{1'b0, 8'h00, 8'h12, 8'h00, 1'b1, 3'd4, 8'h12, 8'h00, 8'h00, 8'hF8},
    '{1'b0, 8'h00, 8'h13, 8'h00, 1'b1, 3'd0, 8'h13, 8'h01, 8'h00, 8'hF8},
    '{1'b0, 8'h00, 8'h13, 8'h00, 1'b1, 3'd1, 8'h11, 8'h00, 8'h00, 8'hF8},
    '{1'b0, 8'h00, 8'h01, 8'h00, 1'b0, 3'd0, 8'h01, 8'h00, 8'h00, 8'hF8}
  };

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Drive after a falling edge, let one rising edge pass, sample at the next fall.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    trig_wr_en = 1'b0;
    ack_valid  = 1'b0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("reset req R10", req_vec, 8'h00);
    chk("reset trig R10", trig_sel, 8'h00);
    chk("reset new R10", new_evt, 8'h00);
    chk("reset masked R10", masked_evt, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      trig_wr_en   = VECS[i].wr;
      trig_wr_data = VECS[i].wdata;
      line_in      = VECS[i].lines;
      line_mask    = VECS[i].mask;
      ack_valid    = VECS[i].av;
      ack_line     = VECS[i].al;
      step();
      chk($sformatf("row%0d req R1 R2 R3 R6 R7", i), req_vec, VECS[i].e_req);
      chk($sformatf("row%0d new R8", i), new_evt, VECS[i].e_new);
      chk($sformatf("row%0d masked R8", i), masked_evt, VECS[i].e_msk);
      chk($sformatf("row%0d trig R5", i), trig_sel, VECS[i].e_trig);
      chk($sformatf("row%0d pend R9", i), pend_vec, VECS[i].e_req & ~VECS[i].mask);
    end

    // R9: pend_vec follows the mask with no clock edge
    line_mask = 8'h01; #1;
    chk("pend masked R9", pend_vec, 8'h00);
    line_mask = 8'h00; #1;
    chk("pend open R9", pend_vec, 8'h01);

    // R5: bits outside 0xF8 never stick
    trig_wr_en = 1'b1; trig_wr_data = 8'h07; step();
    chk("trig low bits R5", trig_sel, 8'h00);
    trig_wr_en = 1'b1; trig_wr_data = 8'h5A; step();
    chk("trig mixed R5", trig_sel, 8'h58);
    trig_wr_en = 1'b1; trig_wr_data = 8'h00; step();
    chk("trig clear R5", trig_sel, 8'h00);

    // R3/R8: held edge request, re-rise gives no fresh flag
    line_in = 8'h00; step();
    chk("edge held on fall R3", req_vec, 8'h01);
    line_in = 8'h01; step();
    chk("re-rise req R2", req_vec, 8'h01);
    chk("re-rise no flag R8", new_evt, 8'h00);
    // R4/R6: ack clears, fall then rise sets again with a fresh flag
    line_in = 8'h00; ack_valid = 1'b1; ack_line = 3'd0; step();
    chk("ack clear R6", req_vec, 8'h00);
    line_in = 8'h01; step();
    chk("prev tracked rise R4", req_vec, 8'h01);
    chk("fresh flag R8", new_evt, 8'h01);

    // R10: mid-run reset, input held high; prev cleared so a rise follows
    rst_n = 1'b0; #1;
    chk("async reset req R10", req_vec, 8'h00);
    @(negedge clk);
    chk("reset new R10", new_evt, 8'h00);
    rst_n = 1'b1;
    step();
    chk("prev cleared by reset R4 R10", req_vec, 8'h01);
    chk("fresh after reset R10", new_evt, 8'h01);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule